// File: doc/BRIEF.md
# SDRAM Byte Mask Timing Unit

This block is the data-mask logic on the device side of a 16-bit synchronous DRAM data bus. Two mask inputs, one per byte lane, decide which halves of the bus take part in each data beat. A small word-addressed store stands in for the memory array. Write bursts place data into it. Read bursts fetch words from it and present them on a read data output, together with one output enable for each byte lane. The output enables model the tri-state buffers: a low enable means that lane floats.

The two directions use different mask timing. On a write, the mask acts on the same clock edge that captures the data, so a masked byte is never stored. On a read, the mask sampled with a beat is carried down a two-stage pipeline with the fetched word. The enable of a masked lane stays low when that word reaches the bus. A masked beat still uses its burst slot, and the burst address advances on every active cycle whatever the mask does.

Top module: `sdram_bytemask_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `oe_hi` and `oe_lo` are low. Reset clears the read pipeline and the burst address.
- R2: `mask_hi` acts only on bits 15:8 and `oe_hi`. `mask_lo` acts only on bits 7:0 and `oe_lo`. Masking one lane never changes the other lane.
- R3: A read beat is an edge where `burst_en`=1 and `wr_sel`=0. The word fetched on that beat is on `rdata` in the cycle after the next edge. In that cycle a lane's enable is 1 only if that lane's mask was 0 on the beat.
- R4: A masked read beat still fetches its word and still advances the address. The beat after it returns the following word.
- R5: A burst starts at `start_addr` on an active edge when the previous edge had `burst_en`=0 or a different `wr_sel`. Each later active edge uses the previous address plus one, modulo DEPTH, whether or not the beat is masked.
- R6: On a write beat (`burst_en`=1, `wr_sel`=1), each lane whose mask is 0 stores its byte of `wdata` at the current address on that same edge.
- R7: On a write beat, a lane whose mask is 1 keeps its previous stored byte.
- R8: In the cycle after a write beat, both enables are low, even if read data is still leaving the pipeline. When no read beat is in the pipeline, both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_en | input | 1 | A burst beat happens on this edge |
| wr_sel | input | 1 | 1 selects write, 0 selects read |
| start_addr | input | ADDR_W | Word address used on the first beat of a burst |
| mask_hi | input | 1 | Mask for bits 15:8 |
| mask_lo | input | 1 | Mask for bits 7:0 |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Read data, two edges after its beat |
| oe_hi | output | 1 | Drive enable for the upper byte |
| oe_lo | output | 1 | Drive enable for the lower byte |

## Verification
A mask pipeline that is one stage too short or too long shows up within one cycle of the first masked read beat. The enable then moves off its beat, which a reference model that is offset by two edges catches at once. A wrong address step, or a mask that blocks the address increment, corrupts every word after the fault in both directions. A write mask applied late or to the wrong lane stays hidden until that address is read back. For that reason every write pattern is followed by a read of the same words.

// File: rtl/sdram_bytemask_unit.sv
module sdram_bytemask_unit #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  burst_en,
  input  logic                  wr_sel,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  mask_hi,
  input  logic                  mask_lo,
  input  logic [2*LANE_W-1:0]   wdata,
  output logic [2*LANE_W-1:0]   rdata,
  output logic                  oe_hi,
  output logic                  oe_lo
);
  localparam int DW    = 2 * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] addr_q, cur;
  logic              act_q, wr_q, first, wr_go, rd_go;
  logic [1:0]        msk;
  logic [DW-1:0]     d1, d2;
  logic [1:0]        m1, m2;
  logic              v1, v2;

  assign msk   = {mask_hi, mask_lo};
  assign wr_go = burst_en && wr_sel;
  assign rd_go = burst_en && !wr_sel;
  assign first = burst_en && (!act_q || (wr_q != wr_sel));
  assign cur   = first ? start_addr : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      act_q <= burst_en;
      wr_q  <= wr_sel;
      if (burst_en) addr_q <= cur + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_go)
      for (int l = 0; l < 2; l++)
        if (!msk[l]) mem[cur][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;  v2 <= 1'b0;
      m1 <= 2'b11; m2 <= 2'b11;
      d1 <= '0;    d2 <= '0;
    end else begin
      v1 <= rd_go;
      m1 <= msk;
      d1 <= mem[cur];
      v2 <= v1;
      m2 <= m1;
      d2 <= d1;
    end
  end

  assign rdata = d2;
  assign oe_hi = v2 && !m2[1] && !(act_q && wr_q);
  assign oe_lo = v2 && !m2[0] && !(act_q && wr_q);

  AST_OE_HI_SOURCE: assert property (@(posedge clk) disable iff (rst)
    oe_hi |-> $past(rd_go && !mask_hi, 2)); // R3
  AST_OE_LO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    oe_lo |-> $past(rd_go && !mask_lo, 2)); // R2
  AST_NO_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_go && !rst) |-> (!oe_hi && !oe_lo)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (burst_en && $past(burst_en && !rst) && wr_sel == $past(wr_sel))
      |-> cur == ADDR_W'($past(cur) + 1'b1)); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !mask_lo) |=> mem[$past(cur)][LANE_W-1:0] == $past(wdata[LANE_W-1:0])); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_go && mask_hi) |=> mem[$past(cur)][DW-1:LANE_W] == $past(mem[cur][DW-1:LANE_W])); // R7
endmodule

// File: tb/sdram_bytemask_unit_test.sv
module sdram_bytemask_unit_test;
  logic clk = 0, rst = 1, burst_en = 0, wr_sel = 0, mask_hi = 0, mask_lo = 0;
  logic [3:0]  start_addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic oe_hi, oe_lo;
  int checks = 0, errors = 0;

  typedef struct { logic rd, wr, mh, ml; logic [15:0] data; int tag; } item_t;
  item_t q[$];
  logic [15:0] mdl [16];
  logic [3:0]  m_addr = 0;
  logic        m_act = 0, m_wr = 0;
  int          tag = 0;

  sdram_bytemask_unit uut (.clk, .rst, .burst_en, .wr_sel, .start_addr,
    .mask_hi, .mask_lo, .wdata, .rdata, .oe_hi, .oe_lo);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input int t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic step(input bit be, input bit wr, input logic [3:0] sa,
                      input bit mh, input bit ml, input logic [15:0] wd);
    item_t it;
    logic [3:0] a;
    @(negedge clk); #1;
    burst_en = be; wr_sel = wr; start_addr = sa; mask_hi = mh; mask_lo = ml; wdata = wd;
    a = (be && (!m_act || m_wr != wr)) ? sa : m_addr;
    if (be) m_addr = a + 1'b1;
    m_act = be; m_wr = wr;
    it.rd = be && !wr; it.wr = be && wr; it.mh = mh; it.ml = ml;
    it.data = mdl[a]; it.tag = tag;
    if (be && wr) begin
      if (!mh) mdl[a][15:8] = wd[15:8];
      if (!ml) mdl[a][7:0]  = wd[7:0];
    end
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() >= 2) begin
      bit eh, el;
      eh = q[0].rd && !q[0].mh && !q[1].wr;
      el = q[0].rd && !q[0].ml && !q[1].wr;
      chk(oe_hi == eh, q[0].tag, "oe_hi", int'(oe_hi), int'(eh));
      chk(oe_lo == el, q[0].tag, "oe_lo", int'(oe_lo), int'(el));
      if (eh) chk(rdata[15:8] == q[0].data[15:8], q[0].tag, "rdata hi", rdata[15:8], q[0].data[15:8]);
      if (el) chk(rdata[7:0] == q[0].data[7:0], q[0].tag, "rdata lo", rdata[7:0], q[0].data[7:0]);
      void'(q.pop_front());
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 'x;
    repeat (3) @(negedge clk);
    chk(!oe_hi && !oe_lo, 1, "reset enables", {oe_hi, oe_lo}, 0); // R1
    #1 rst = 0;
    q.delete();
    q.push_back('{rd: 0, wr: 0, mh: 0, ml: 0, data: 0, tag: 1});
    tag = 1; idle(2);                                              // R1 first cycles quiet
    tag = 6; for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0, {8'(i*3+1), 8'(i*7+2)}); // R6
    idle(1);
    tag = 3; for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);                     // R3
    idle(3);
    tag = 7; for (int i = 0; i < 6; i++) step(1, 1, 4, i[0], 0, {8'(200+i), 8'(100+i)}); // R7
    idle(1);
    for (int i = 0; i < 6; i++) step(1, 0, 4, 0, 0, 0);                               // R7 readback
    idle(3);
    tag = 2; for (int i = 0; i < 4; i++) step(1, 1, 10, 0, 1, {8'(50+i), 8'(60+i)});  // R2
    idle(1);
    for (int i = 0; i < 4; i++) step(1, 0, 10, i[0], !i[0], 0);                        // R2 single lane
    idle(3);
    tag = 4; for (int i = 0; i < 12; i++) step(1, 0, 2, (i % 3) == 1, i > 5, 0);       // R4 mid-burst
    idle(3);
    tag = 5; for (int i = 0; i < 4; i++) step(1, 1, 14, 0, 0, {8'(90+i), 8'(80+i)});  // R5 wrap
    for (int i = 0; i < 5; i++) step(1, 0, 13, 0, 0, 0);                               // R5 restart
    idle(3);
    tag = 8; for (int i = 0; i < 3; i++) step(1, 0, 5, 0, 0, 0);                       // R8
    for (int i = 0; i < 2; i++) step(1, 1, 5, 1, 1, 16'hFFFF);                         // R8 gating
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule